// File: doc/BRIEF.md
# Exclusive Access Monitor

This block lets several cores that share one word store build atomic read-modify-write sequences out of a reserving load and a conditional store. A core issues a reserving load, which returns the addressed word and records a reservation for that core on that word. It later issues a conditional store to the same word. The store writes only if the core's reservation is still intact, and the core receives a pass/fail code so that software can retry the sequence on failure. Reservations are lost when another core successfully writes the reserved word, when the core issues a conditional store, or when the core's clear input is raised on a context switch or exception.

Every core has its own request channel: an operation code, a word address and write data, plus a clear line. All requests present in one cycle are handled in that cycle, one after another in ascending core index. Each request sees the effects of the lower-indexed requests before it. Responses appear on registered per-core outputs one cycle after the request. The word store is a small internal register bank of 2^AW words.

Top module: `excl_monitor`

## Requirements
- R1: After reset every stored word is zero, no core holds a reservation, and `rsp_vld` is low on every core.
- R2: A plain read (op code 1) or a reserving read (op code 3) from a core returns the addressed word on that core's `rsp_rdata`, with `rsp_vld` high, in the cycle after the request. A plain write (op code 2) stores the word unconditionally.
- R3: A reserving read records a reservation for the requesting core on the addressed word. A later conditional store (op code 4) from that core to that word writes the data and reports `rsp_fail` = 0.
- R4: A conditional store that finds no matching reservation reports `rsp_fail` = 1 and leaves the stored word unchanged. `rsp_fail` is high only for such a store.
- R5: A conditional store removes the requesting core's own reservation, whether it passes or fails. A second conditional store without a new reserving read therefore fails.
- R6: A conditional store to a word other than the one the core has reserved fails, even though the core holds a reservation.
- R7: Each core holds at most one reservation. A new reserving read replaces the previous one, so a conditional store to the previously reserved word fails.
- R8: A successful write (plain write, or conditional store that passes) by one core to a word removes every other core's reservation on that word. Reservations on other words are kept.
- R9: A plain write by a core to its own reserved word leaves that core's reservation in place.
- R10: Raising `clr_resv` for a core removes that core's reservation. The clear is applied before that cycle's requests, so a reserving read issued in the same cycle still takes effect.
- R11: Requests from several cores in one cycle are applied in ascending core index, each observing the stored words and reservations left by the lower-indexed requests of that cycle.
- R12: Op code 0 is idle. Codes 5 to 7 act as idle: no response and no effect on words or reservations. `rsp_rdata` is zero for responses to writes, and `rsp_fail` is zero for every response except a failed conditional store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | NC*3 | Per-core operation code, core i at bits [3i+2:3i] |
| req_addr | input | NC*AW | Per-core word address |
| req_wdata | input | NC*DW | Per-core write data |
| clr_resv | input | NC | Per-core reservation clear |
| rsp_vld | output | NC | Per-core response valid, one cycle after a request |
| rsp_rdata | output | NC*DW | Per-core read data |
| rsp_fail | output | NC | Per-core conditional-store failure flag |

## Verification
The bench builds the default configuration: three cores, sixteen words and eight-bit data. With this configuration every core can be swept over all 256 pairs of reserved and stored addresses, and all eight op codes can be driven. A long pseudo-random run confines addresses to four words so that three-way collisions within one cycle are frequent. This tests the ascending-index ordering and cross-core cancellation against an arithmetic model. Directed sequences cover replacement, self-write retention and the clear-before-request ordering.

// File: rtl/excl_pkg.sv
package excl_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE       = 3'd0,
        OP_READ       = 3'd1,
        OP_WRITE      = 3'd2,
        OP_READ_LINK  = 3'd3,
        OP_WRITE_COND = 3'd4
    } op_e;

    // Decoded request class carried down the serialisation chain.
    typedef struct packed {
        logic rd;    // returns a word
        logic wr;    // may write a word
        logic link;  // records a reservation
        logic cond;  // write gated by reservation
    } op_dec_t;

    function automatic op_dec_t decode_op(logic [OP_W-1:0] raw);
        op_dec_t d;
        d = '0;
        case (raw)
            OP_READ:       d.rd = 1'b1;
            OP_WRITE:      d.wr = 1'b1;
            OP_READ_LINK:  begin d.rd = 1'b1; d.link = 1'b1; end
            OP_WRITE_COND: begin d.wr = 1'b1; d.cond = 1'b1; end
            default:       d = '0;
        endcase
        return d;
    endfunction

    function automatic logic wants_rsp(op_dec_t d);
        return d.rd | d.wr;
    endfunction

endpackage

// File: rtl/excl_front.sv
module excl_front
    import excl_pkg::*;
#(
    parameter int NC = 3
) (
    input  logic [NC*OP_W-1:0] req_op,
    input  logic [NC-1:0]      clr,
    input  logic [NC-1:0]      rv_in,
    output op_dec_t [NC-1:0]   dec,
    output logic [NC-1:0]      rv_out
);

    for (genvar g = 0; g < NC; g++) begin : g_dec
        assign dec[g] = decode_op(req_op[g*OP_W +: OP_W]);
    end

    // Clears land before any request of the same cycle.
    assign rv_out = rv_in & ~clr;

endmodule

// File: rtl/excl_stage.sv
module excl_stage
    import excl_pkg::*;
#(
    parameter int NC  = 3,
    parameter int AW  = 4,
    parameter int DW  = 8,
    parameter int IDX = 0
) (
    input  op_dec_t                          dec,
    input  logic [AW-1:0]                    addr,
    input  logic [DW-1:0]                    wdata,
    input  logic [NC-1:0]                    rv_in,
    input  logic [NC-1:0][AW-1:0]            ra_in,
    input  logic [(1<<AW)-1:0][DW-1:0]       mem_in,
    output logic [NC-1:0]                    rv_out,
    output logic [NC-1:0][AW-1:0]            ra_out,
    output logic [(1<<AW)-1:0][DW-1:0]       mem_out,
    output logic [DW-1:0]                    rdata,
    output logic                             fail
);

    logic own_hit;
    logic commit;

    assign own_hit = rv_in[IDX] && (ra_in[IDX] == addr);
    assign commit  = dec.wr && (!dec.cond || own_hit);
    assign rdata   = dec.rd ? mem_in[addr] : '0;
    assign fail    = dec.cond && !own_hit;

    always_comb begin
        mem_out = mem_in;
        if (commit) begin
            mem_out[addr] = wdata;
        end
    end

    always_comb begin
        rv_out = rv_in;
        ra_out = ra_in;
        for (int j = 0; j < NC; j++) begin
            if (commit && (j != IDX) && rv_in[j] && (ra_in[j] == addr)) begin
                rv_out[j] = 1'b0;
            end
        end
        if (dec.link) begin
            rv_out[IDX] = 1'b1;
            ra_out[IDX] = addr;
        end
        if (dec.cond) begin
            rv_out[IDX] = 1'b0;
        end
    end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_pkg::*;
#(
    parameter int NC = 3,
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NC*OP_W-1:0]   req_op,
    input  logic [NC*AW-1:0]     req_addr,
    input  logic [NC*DW-1:0]     req_wdata,
    input  logic [NC-1:0]        clr_resv,
    output logic [NC-1:0]        rsp_vld,
    output logic [NC*DW-1:0]     rsp_rdata,
    output logic [NC-1:0]        rsp_fail
);

    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0][DW-1:0] mem_q;
    logic [NC-1:0]            rv_q;
    logic [NC-1:0][AW-1:0]    ra_q;

    op_dec_t [NC-1:0] dec;
    logic [NC-1:0]    rv_clr;

    // Serialisation chain: element k is the state seen by core k.
    logic [NC:0][NC-1:0]            rv_c;
    logic [NC:0][NC-1:0][AW-1:0]    ra_c;
    logic [NC:0][DEPTH-1:0][DW-1:0] mem_c;
    logic [NC-1:0][DW-1:0]          rdata_c;
    logic [NC-1:0]                  fail_c;

    logic [NC-1:0]                  vld_q;
    logic [NC-1:0][DW-1:0]          rdata_q;
    logic [NC-1:0]                  fail_q;

    excl_front #(.NC(NC)) u_front (
        .req_op (req_op),
        .clr    (clr_resv),
        .rv_in  (rv_q),
        .dec    (dec),
        .rv_out (rv_clr)
    );

    assign rv_c[0]  = rv_clr;
    assign ra_c[0]  = ra_q;
    assign mem_c[0] = mem_q;

    for (genvar g = 0; g < NC; g++) begin : g_stage
        excl_stage #(.NC(NC), .AW(AW), .DW(DW), .IDX(g)) u_stage (
            .dec     (dec[g]),
            .addr    (req_addr[g*AW +: AW]),
            .wdata   (req_wdata[g*DW +: DW]),
            .rv_in   (rv_c[g]),
            .ra_in   (ra_c[g]),
            .mem_in  (mem_c[g]),
            .rv_out  (rv_c[g+1]),
            .ra_out  (ra_c[g+1]),
            .mem_out (mem_c[g+1]),
            .rdata   (rdata_c[g]),
            .fail    (fail_c[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q   <= '0;
            rv_q    <= '0;
            ra_q    <= '0;
            vld_q   <= '0;
            rdata_q <= '0;
            fail_q  <= '0;
        end else begin
            mem_q <= mem_c[NC];
            rv_q  <= rv_c[NC];
            ra_q  <= ra_c[NC];
            for (int i = 0; i < NC; i++) begin
                vld_q[i]   <= wants_rsp(dec[i]);
                rdata_q[i] <= rdata_c[i];
                fail_q[i]  <= fail_c[i];
            end
        end
    end

    assign rsp_vld = vld_q;
    assign rsp_fail = fail_q;
    for (genvar g = 0; g < NC; g++) begin : g_out
        assign rsp_rdata[g*DW +: DW] = rdata_q[g];
    end

    for (genvar g = 0; g < NC; g++) begin : g_chk
        p_rsp_needs_req_r12: assert property (@(posedge clk) disable iff (rst)
            vld_q[g] |-> $past(wants_rsp(dec[g])));

        p_fail_has_rsp_r4: assert property (@(posedge clk) disable iff (rst)
            fail_q[g] |-> vld_q[g]);

        p_cond_drops_own_r5: assert property (@(posedge clk) disable iff (rst)
            dec[g].cond |=> !rv_q[g]);

        p_cond_unreserved_fails_r6: assert property (@(posedge clk) disable iff (rst)
            (dec[g].cond && !rv_q[g]) |=> fail_q[g]);

        p_clear_drops_r10: assert property (@(posedge clk) disable iff (rst)
            (clr_resv[g] && !dec[g].link) |=> !rv_q[g]);
    end

endmodule

// File: tb/excl_monitor_tb.sv
module excl_monitor_tb;

    localparam int NC = 3;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NC*3-1:0]   req_op = '0;
    logic [NC*AW-1:0]  req_addr = '0;
    logic [NC*DW-1:0]  req_wdata = '0;
    logic [NC-1:0]     clr_resv = '0;
    logic [NC-1:0]     rsp_vld;
    logic [NC*DW-1:0]  rsp_rdata;
    logic [NC-1:0]     rsp_fail;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Bench-side model state.
    logic [DW-1:0] mm [DEPTH];
    logic          mv [NC];
    logic [AW-1:0] ma [NC];

    // Staged request of the next cycle.
    logic [2:0]    op_b [NC];
    logic [AW-1:0] ad_b [NC];
    logic [DW-1:0] wd_b [NC];
    logic          cl_b [NC];

    logic          e_vld [NC];
    logic [DW-1:0] e_rd  [NC];
    logic          e_f   [NC];

    always #5 clk = ~clk;

    excl_monitor #(.NC(NC), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .clr_resv(clr_resv), .rsp_vld(rsp_vld),
        .rsp_rdata(rsp_rdata), .rsp_fail(rsp_fail)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        for (int i = 0; i < NC; i++) begin
            op_b[i] = 3'd0; ad_b[i] = '0; wd_b[i] = '0; cl_b[i] = 1'b0;
        end
    endtask

    task automatic put(int c, logic [2:0] op, int a, int d);
        op_b[c] = op; ad_b[c] = AW'(a); wd_b[c] = DW'(d);
    endtask

    task automatic model_store(int c, logic [AW-1:0] a, logic [DW-1:0] d);
        mm[a] = d;
        for (int j = 0; j < NC; j++)
            if (j != c && mv[j] && ma[j] == a) mv[j] = 1'b0;
    endtask

    // Drives the staged request at a falling edge, predicts, compares at the next.
    task automatic run_cycle(string tag);
        logic hit;
        for (int i = 0; i < NC; i++) begin
            req_op[i*3 +: 3]     = op_b[i];
            req_addr[i*AW +: AW] = ad_b[i];
            req_wdata[i*DW +: DW] = wd_b[i];
            clr_resv[i]          = cl_b[i];
        end
        for (int i = 0; i < NC; i++) if (cl_b[i]) mv[i] = 1'b0;
        for (int i = 0; i < NC; i++) begin
            e_vld[i] = 1'b0; e_rd[i] = '0; e_f[i] = 1'b0;
            case (op_b[i])
                3'd1: begin e_vld[i] = 1'b1; e_rd[i] = mm[ad_b[i]]; end
                3'd2: begin e_vld[i] = 1'b1; model_store(i, ad_b[i], wd_b[i]); end
                3'd3: begin
                    e_vld[i] = 1'b1; e_rd[i] = mm[ad_b[i]];
                    mv[i] = 1'b1; ma[i] = ad_b[i];
                end
                3'd4: begin
                    hit = mv[i] && (ma[i] == ad_b[i]);
                    e_vld[i] = 1'b1; e_f[i] = !hit;
                    if (hit) model_store(i, ad_b[i], wd_b[i]);
                    mv[i] = 1'b0;
                end
                default: ;
            endcase
        end
        @(negedge clk);
        for (int i = 0; i < NC; i++) begin
            chk(rsp_vld[i] == e_vld[i], $sformatf("%s core%0d vld", tag, i), rsp_vld[i], e_vld[i]);
            chk(rsp_rdata[i*DW +: DW] == e_rd[i], $sformatf("%s core%0d rdata", tag, i),
                rsp_rdata[i*DW +: DW], e_rd[i]);
            chk(rsp_fail[i] == e_f[i], $sformatf("%s core%0d fail", tag, i), rsp_fail[i], e_f[i]);
        end
        idle_all();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int unsigned lf;
        for (int k = 0; k < DEPTH; k++) mm[k] = '0;
        for (int i = 0; i < NC; i++) begin mv[i] = 1'b0; ma[i] = '0; end
        idle_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(rsp_vld == '0, "R1 rsp_vld after reset", rsp_vld, 0);
        for (int a = 0; a < DEPTH; a++) begin
            put(a % NC, 3'd1, a, 0);
            run_cycle("R1 zero word");
        end
        put(0, 3'd4, 2, 8'h11); put(1, 3'd4, 3, 8'h22); put(2, 3'd4, 4, 8'h33);
        run_cycle("R1 no reservation");
        chk(rsp_fail == 3'b111, "R1 cond stores fail", rsp_fail, 3'b111);

        // R2: plain write then read from another core
        put(0, 3'd2, 5, 8'h5A); run_cycle("R2 write");
        put(1, 3'd1, 5, 0); run_cycle("R2 read");
        chk(rsp_rdata[DW +: DW] == 8'h5A, "R2 read back", rsp_rdata[DW +: DW], 8'h5A);

        // R3 / R6: sweep reserved vs stored address for every core
        for (int c = 0; c < NC; c++)
            for (int a = 0; a < DEPTH; a++)
                for (int b = 0; b < DEPTH; b++) begin
                    put(c, 3'd3, a, 0); run_cycle("R3 reserve");
                    put(c, 3'd4, b, (c * 64 + a * 4 + b) & 8'hFF);
                    run_cycle(a == b ? "R3 cond store match" : "R6 cond store other word");
                end

        // R4 / R5: failed store leaves word, own reservation consumed
        put(2, 3'd3, 7, 0); run_cycle("R5 reserve");
        put(2, 3'd4, 7, 8'hA1); run_cycle("R5 first store");
        chk(rsp_fail[2] == 1'b0, "R5 first store passes", rsp_fail[2], 0);
        put(2, 3'd4, 7, 8'hB2); run_cycle("R5 second store");
        chk(rsp_fail[2] == 1'b1, "R5 second store fails", rsp_fail[2], 1);
        put(0, 3'd1, 7, 0); run_cycle("R4 word unchanged");
        chk(rsp_rdata[DW-1:0] == 8'hA1, "R4 word kept", rsp_rdata[DW-1:0], 8'hA1);

        // R7: replacement
        put(1, 3'd3, 8, 0); run_cycle("R7 reserve old");
        put(1, 3'd3, 9, 0); run_cycle("R7 reserve new");
        put(1, 3'd4, 8, 8'h44); run_cycle("R7 old word store");
        chk(rsp_fail[1] == 1'b1, "R7 old reservation gone", rsp_fail[1], 1);

        // R8: foreign write cancels, unrelated word does not
        put(0, 3'd3, 10, 0); put(1, 3'd3, 11, 0); run_cycle("R8 reserve");
        put(2, 3'd2, 10, 8'h66); run_cycle("R8 foreign write");
        put(0, 3'd4, 10, 8'h77); put(1, 3'd4, 11, 8'h88); run_cycle("R8 outcome");
        chk(rsp_fail[1:0] == 2'b01, "R8 only hit core fails", rsp_fail[1:0], 2'b01);

        // R9: own plain write keeps reservation
        put(2, 3'd3, 12, 0); run_cycle("R9 reserve");
        put(2, 3'd2, 12, 8'h12); run_cycle("R9 own write");
        put(2, 3'd4, 12, 8'h13); run_cycle("R9 cond store");
        chk(rsp_fail[2] == 1'b0, "R9 reservation kept", rsp_fail[2], 0);

        // R10: clear drops; clear plus reserving read same cycle keeps new one
        put(0, 3'd3, 13, 0); run_cycle("R10 reserve");
        cl_b[0] = 1'b1; run_cycle("R10 clear");
        put(0, 3'd4, 13, 8'h21); run_cycle("R10 store after clear");
        chk(rsp_fail[0] == 1'b1, "R10 cleared", rsp_fail[0], 1);
        put(0, 3'd3, 13, 0); cl_b[0] = 1'b1; run_cycle("R10 clear with reserve");
        put(0, 3'd4, 13, 8'h22); run_cycle("R10 store");
        chk(rsp_fail[0] == 1'b0, "R10 same cycle reserve kept", rsp_fail[0], 0);

        // R11: ordering within one cycle
        put(0, 3'd2, 14, 8'h9C); put(1, 3'd1, 14, 0); run_cycle("R11 write before read");
        chk(rsp_rdata[DW +: DW] == 8'h9C, "R11 core1 sees core0 write", rsp_rdata[DW +: DW], 8'h9C);
        put(0, 3'd3, 15, 0); put(1, 3'd2, 15, 8'h01); run_cycle("R11 reserve then foreign write");
        put(0, 3'd4, 15, 8'h02); run_cycle("R11 lost");
        chk(rsp_fail[0] == 1'b1, "R11 lower reservation cancelled", rsp_fail[0], 1);
        put(0, 3'd2, 15, 8'h03); put(1, 3'd3, 15, 0); run_cycle("R11 write then reserve");
        put(1, 3'd4, 15, 8'h04); run_cycle("R11 kept");
        chk(rsp_fail[1] == 1'b0, "R11 higher reservation survives", rsp_fail[1], 0);

        // R12: unused codes have no effect
        put(1, 3'd3, 6, 0); run_cycle("R12 reserve");
        for (int op = 5; op < 8; op++) begin
            put(0, 3'(op), 6, 8'hEE); put(2, 3'(op), 6, 8'hEE); run_cycle("R12 unused code");
            chk(rsp_vld == 3'b000, "R12 no response", rsp_vld, 0);
        end
        put(1, 3'd4, 6, 8'h5F); run_cycle("R12 reservation intact");
        chk(rsp_fail[1] == 1'b0, "R12 cond store passes", rsp_fail[1], 0);

        // R11: pseudo-random collisions on four words
        lf = 32'h1ACE5EED;
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < NC; i++) begin
                lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
                put(i, 3'(lf[2:0]), int'(lf[9:8]), int'(lf[23:16]));
                cl_b[i] = (lf[31:28] == 4'h0);
            end
            run_cycle("R11 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule